// File: doc/BRIEF.md
# Filtered Quadrature and Index Decoder

This block turns the raw phase A, phase B and index signals of one incremental encoder axis into count events for a separate position counter. A per-axis divider derives a filter sampling tick from the block clock. Each of the three inputs is accepted at a new level only after that level has been seen unchanged across two full filter periods. The clean phase pair is then decoded at one, two or four counts per quadrature cycle. Alternatively, a clock/direction mode counts rising edges of A, with B giving the direction, and in that mode the filter is skipped.

The index input can request one of three actions from the counter: load it from its preset, clear it, or copy it into a snapshot latch. In quadrature modes the index is honoured only while A and B are equal. Each time the qualifying condition begins, one strobe is issued. All configuration comes from fields of an external mode register, applied to the configuration ports.

Top module: `qdec_axis`

## Requirements
- R1: With `cfg_div2`=0 the filter samples on every clock. With `cfg_div2`=1 it samples on every second clock, so a three-cycle pulse is rejected, while a six-cycle pulse is accepted.
- R2: A filtered level changes only after the input has held the new value at three consecutive filter samples. A pulse shorter than that produces no count.
- R3: `cfg_res` selects the counting mode: 2'b00 clock/direction, 2'b01 x1, 2'b10 x2, 2'b11 x4. In x4, every legal change of the filtered A/B pair counts once.
- R4: In quadrature modes, the sequence 00→10→11→01→00 (written {A,B}, so A leads) counts up. The reverse order counts down.
- R5: x1 counts up on A rising while B is low and down on A falling while B is low. x2 counts every edge of A, up when A and B differ after the edge and down when they are equal.
- R6: A filtered step in which A and B change together produces no count.
- R7: In clock/direction mode, each rising edge of A makes one count: up if B is high, down if B is low. A single-cycle pulse on A is enough.
- R8: `cnt_en` is high for exactly one clock per count. `cnt_up` gives the direction of the latest count and holds it until the next count.
- R9: `cfg_idx` selects the index action: 2'b00 none, 2'b01 `idx_load`, 2'b10 `idx_clear`, 2'b11 `idx_snap`. At most one strobe is high at a time.
- R10: The index is active when its level equals `cfg_idx_hi` (0 = active low, 1 = active high).
- R11: In quadrature modes, the index qualifies only while it is active and A equals B. In clock/direction mode, the active level alone qualifies.
- R12: A strobe lasts one clock and is issued once, when the qualifying condition begins. After reset, no strobe is issued until the index has first been seen unqualified.
- R13: During reset, and right after it while the inputs are idle, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_res | input | 2 | Counting mode |
| cfg_idx | input | 2 | Index action select |
| cfg_idx_hi | input | 1 | Index active level |
| cfg_div2 | input | 1 | Filter clock divide by two |
| enc_a | input | 1 | Raw phase A / count clock |
| enc_b | input | 1 | Raw phase B / direction |
| enc_idx | input | 1 | Raw index |
| cnt_en | output | 1 | One-cycle count event |
| cnt_up | output | 1 | Direction of latest count |
| idx_load | output | 1 | Load-counter strobe |
| idx_clear | output | 1 | Clear-counter strobe |
| idx_snap | output | 1 | Snapshot strobe |

## Verification
A corrupted filter history or a bad divider phase shows up within a few filter periods as a lost or extra count after a short pulse. A wrong previous A/B state shows up on the very next filtered step as a count with the wrong sign, or as a count on an illegal double change. A stuck index-qualification register shows up as a missing or repeated strobe when the index next enters or leaves its active quadrant. The expected count totals per step are fixed in a table, and the outputs are compared after each hold period of the inputs.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    RES_CLKDIR = 2'b00,
    RES_X1     = 2'b01,
    RES_X2     = 2'b10,
    RES_X4     = 2'b11
  } res_e;

  typedef enum logic [1:0] {
    IDX_NONE  = 2'b00,
    IDX_LOAD  = 2'b01,
    IDX_CLEAR = 2'b10,
    IDX_SNAP  = 2'b11
  } idx_e;

  typedef struct packed {
    logic hit;
    logic up;
  } step_t;

  // One filtered A/B step; ab vectors are {A,B}.
  function automatic step_t quad_step(input logic [1:0] prev_ab,
                                      input logic [1:0] cur_ab,
                                      input res_e       res);
    step_t s;
    logic  a_moved, b_moved;
    a_moved = prev_ab[1] ^ cur_ab[1];
    b_moved = prev_ab[0] ^ cur_ab[0];
    // A leading: after an A edge the phases differ, after a B edge they match
    s.up  = a_moved ? (cur_ab[1] ^ cur_ab[0]) : ~(cur_ab[1] ^ cur_ab[0]);
    s.hit = 1'b0;
    if (a_moved ^ b_moved) begin
      case (res)
        RES_X4:  s.hit = 1'b1;
        RES_X2:  s.hit = a_moved;
        RES_X1:  s.hit = a_moved & ~cur_ab[0];
        default: s.hit = 1'b0;
      endcase
    end
    return s;
  endfunction

  function automatic logic in_quadrant(input logic [1:0] ab);
    return ~(ab[1] ^ ab[0]);
  endfunction

endpackage

// File: rtl/qdec_tick.sv
module qdec_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic div2,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign tick = div2 ? phase : 1'b1;
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int W       = 3,
  parameter int SAMPLES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  localparam int HW = SAMPLES - 1;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [HW-1:0] hist;
    logic          lvl;
    logic [HW:0]   window;

    assign window = {hist, raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist <= '0;
        lvl  <= 1'b0;
      end else if (tick) begin
        hist <= window[HW-1:0];
        if (&window)       lvl <= 1'b1;
        else if (~|window) lvl <= 1'b0;
      end
    end

    assign clean[g] = lvl;
  end
endmodule

// File: rtl/qdec_core.sv
module qdec_core
  import qdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  res_e res,
  input  idx_e idx_mode,
  input  logic idx_hi,
  input  logic flt_a,
  input  logic flt_b,
  input  logic flt_i,
  input  logic raw_a,
  input  logic raw_b,
  input  logic raw_i,
  output logic cnt_en,
  output logic cnt_up,
  output logic idx_load,
  output logic idx_clear,
  output logic idx_snap
);
  logic [1:0] ab_prev;
  logic       cd_a1, cd_a2, cd_b1, cd_i1;
  logic       qual_prev;
  step_t      qs;
  logic       clkdir, ev_count, ev_up, idx_lvl, idx_qual, idx_entry;

  assign clkdir    = (res == RES_CLKDIR);
  assign qs        = quad_step(ab_prev, {flt_a, flt_b}, res);
  assign ev_count  = clkdir ? (cd_a1 & ~cd_a2) : qs.hit;
  assign ev_up     = clkdir ? cd_b1 : qs.up;
  assign idx_lvl   = clkdir ? cd_i1 : flt_i;
  assign idx_qual  = (idx_lvl == idx_hi) & (clkdir | in_quadrant({flt_a, flt_b}));
  assign idx_entry = idx_qual & ~qual_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_prev   <= 2'b00;
      cd_a1     <= 1'b0;
      cd_a2     <= 1'b0;
      cd_b1     <= 1'b0;
      cd_i1     <= 1'b0;
      qual_prev <= 1'b1;
      cnt_en    <= 1'b0;
      cnt_up    <= 1'b0;
      idx_load  <= 1'b0;
      idx_clear <= 1'b0;
      idx_snap  <= 1'b0;
    end else begin
      ab_prev   <= {flt_a, flt_b};
      cd_a1     <= raw_a;
      cd_a2     <= cd_a1;
      cd_b1     <= raw_b;
      cd_i1     <= raw_i;
      qual_prev <= idx_qual;
      cnt_en    <= ev_count;
      if (ev_count) cnt_up <= ev_up;
      idx_load  <= idx_entry & (idx_mode == IDX_LOAD);
      idx_clear <= idx_entry & (idx_mode == IDX_CLEAR);
      idx_snap  <= idx_entry & (idx_mode == IDX_SNAP);
    end
  end
endmodule

// File: rtl/qdec_axis.sv
module qdec_axis
  import qdec_pkg::*;
#(
  parameter int FILT_SAMPLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_res,
  input  logic [1:0] cfg_idx,
  input  logic       cfg_idx_hi,
  input  logic       cfg_div2,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic       enc_idx,
  output logic       cnt_en,
  output logic       cnt_up,
  output logic       idx_load,
  output logic       idx_clear,
  output logic       idx_snap
);
  localparam int NSIG = 3;

  logic            tick;
  logic [NSIG-1:0] flt_abi;

  qdec_tick u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .div2  (cfg_div2),
    .tick  (tick)
  );

  qdec_filter #(.W(NSIG), .SAMPLES(FILT_SAMPLES)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .raw   ({enc_a, enc_b, enc_idx}),
    .clean (flt_abi)
  );

  qdec_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .res       (res_e'(cfg_res)),
    .idx_mode  (idx_e'(cfg_idx)),
    .idx_hi    (cfg_idx_hi),
    .flt_a     (flt_abi[2]),
    .flt_b     (flt_abi[1]),
    .flt_i     (flt_abi[0]),
    .raw_a     (enc_a),
    .raw_b     (enc_b),
    .raw_i     (enc_idx),
    .cnt_en    (cnt_en),
    .cnt_up    (cnt_up),
    .idx_load  (idx_load),
    .idx_clear (idx_clear),
    .idx_snap  (idx_snap)
  );
endmodule

// File: rtl/qdec_axis_chk.sv
module qdec_axis_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_res,
  input logic [1:0] cfg_idx,
  input logic       cfg_div2,
  input logic       tick,
  input logic [2:0] flt_abi,
  input logic       cnt_en,
  input logic       idx_load,
  input logic       idx_clear,
  input logic       idx_snap
);
  assert_tick_alt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div2 && tick) |=> (!cfg_div2 || !tick));

  assert_filter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(flt_abi));

  assert_filter_no_bounce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_abi[2] != $past(flt_abi[2])) |=> $stable(flt_abi[2]));

  assert_illegal_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_res != 2'b00) && ((flt_abi[2:1] ^ $past(flt_abi[2:1])) == 2'b11)) |=> !cnt_en);

  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idx_load, idx_clear, idx_snap}));

  assert_idx_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_idx == 2'b00) && ($past(cfg_idx) == 2'b00)) |-> !(idx_load || idx_clear || idx_snap));

  assert_load_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |-> ($past(cfg_idx) == 2'b01));

  assert_clear_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clear |-> ($past(cfg_idx) == 2'b10));

  assert_strobe_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_load || idx_clear || idx_snap) |=> !(idx_load || idx_clear || idx_snap));
endmodule

bind qdec_axis qdec_axis_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_res   (cfg_res),
  .cfg_idx   (cfg_idx),
  .cfg_div2  (cfg_div2),
  .tick      (tick),
  .flt_abi   (flt_abi),
  .cnt_en    (cnt_en),
  .idx_load  (idx_load),
  .idx_clear (idx_clear),
  .idx_snap  (idx_snap)
);

// File: tb/qdec_axis_tb_top.sv
module qdec_axis_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mode = 8'h03;
  logic       enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic       cnt_en, cnt_up, idx_load, idx_clear, idx_snap;
  int         n_checks = 0, n_errors = 0;
  int         n_up = 0, n_dn = 0, n_ld = 0, n_cl = 0, n_sn = 0;

  // 100 MHz: 10-unit period
  always #5 clk = ~clk;

  // mode byte: [7] div2, [6] index active high, [5:4] index action, [1:0] counting mode
  qdec_axis dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_res(mode[1:0]), .cfg_idx(mode[5:4]), .cfg_idx_hi(mode[6]), .cfg_div2(mode[7]),
    .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .cnt_en(cnt_en), .cnt_up(cnt_up),
    .idx_load(idx_load), .idx_clear(idx_clear), .idx_snap(idx_snap)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (cnt_en && cnt_up)  n_up++;
      if (cnt_en && !cnt_up) n_dn++;
      if (idx_load)  n_ld++;
      if (idx_clear) n_cl++;
      if (idx_snap)  n_sn++;
    end
  end

  typedef struct packed {
    logic [7:0] m;
    logic [2:0] abi;
    logic [1:0] ud;
    logic [2:0] stb;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{8'h03, 3'b100, 2'b10, 3'b000}, '{8'h03, 3'b110, 2'b10, 3'b000},
    '{8'h03, 3'b010, 2'b10, 3'b000}, '{8'h03, 3'b000, 2'b10, 3'b000},
    '{8'h03, 3'b010, 2'b01, 3'b000}, '{8'h03, 3'b110, 2'b01, 3'b000},
    '{8'h03, 3'b100, 2'b01, 3'b000}, '{8'h03, 3'b000, 2'b01, 3'b000},
    '{8'h03, 3'b110, 2'b00, 3'b000}, '{8'h03, 3'b000, 2'b00, 3'b000},
    '{8'h02, 3'b100, 2'b10, 3'b000}, '{8'h02, 3'b110, 2'b00, 3'b000},
    '{8'h02, 3'b010, 2'b10, 3'b000}, '{8'h02, 3'b000, 2'b00, 3'b000},
    '{8'h02, 3'b010, 2'b00, 3'b000}, '{8'h02, 3'b110, 2'b01, 3'b000},
    '{8'h02, 3'b100, 2'b00, 3'b000}, '{8'h02, 3'b000, 2'b01, 3'b000},
    '{8'h01, 3'b100, 2'b10, 3'b000}, '{8'h01, 3'b110, 2'b00, 3'b000},
    '{8'h01, 3'b010, 2'b00, 3'b000}, '{8'h01, 3'b000, 2'b00, 3'b000},
    '{8'h01, 3'b010, 2'b00, 3'b000}, '{8'h01, 3'b110, 2'b00, 3'b000},
    '{8'h01, 3'b100, 2'b00, 3'b000}, '{8'h01, 3'b000, 2'b01, 3'b000},
    '{8'h53, 3'b001, 2'b00, 3'b100}, '{8'h53, 3'b101, 2'b10, 3'b000},
    '{8'h53, 3'b111, 2'b10, 3'b100}, '{8'h53, 3'b110, 2'b00, 3'b000},
    '{8'h53, 3'b100, 2'b01, 3'b000}, '{8'h53, 3'b101, 2'b00, 3'b000},
    '{8'h53, 3'b100, 2'b00, 3'b000}, '{8'h53, 3'b000, 2'b01, 3'b000},
    '{8'h00, 3'b010, 2'b00, 3'b000}, '{8'h00, 3'b110, 2'b10, 3'b000},
    '{8'h00, 3'b010, 2'b00, 3'b000}, '{8'h00, 3'b000, 2'b00, 3'b000},
    '{8'h00, 3'b100, 2'b01, 3'b000}, '{8'h00, 3'b000, 2'b00, 3'b000},
    '{8'h83, 3'b100, 2'b10, 3'b000}, '{8'h83, 3'b000, 2'b01, 3'b000}
  };

  function automatic string row_tag(input int r);
    if (r < 8)  return "R3 R4";
    if (r < 10) return "R6";
    if (r < 26) return "R5";
    if (r < 34) return "R9 R11";
    if (r < 40) return "R7";
    return "R1";
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_cnt();
    n_up = 0; n_dn = 0; n_ld = 0; n_cl = 0; n_sn = 0;
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic a, input logic b, input logic i);
    enc_a = a; enc_b = b; enc_idx = i;
  endtask

  task automatic reset_with(input logic [7:0] m, input logic a, input logic b, input logic i);
    @(negedge clk);
    rst_n = 1'b0; mode = m; drive(a, b, i);
    hold(3);
    rst_n = 1'b1;
    hold(12);
    clr_cnt();
  endtask

  task automatic pulse_a(input int len);
    enc_a = 1'b1; hold(len); enc_a = 1'b0; hold(14);
  endtask

  int summary_done = 0;

  task automatic finish_run();
    if (summary_done == 0) begin
      summary_done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R13 reset state
    hold(2);
    chk("R13 outputs in reset", {cnt_en, cnt_up, idx_load, idx_clear, idx_snap}, 0);
    rst_n = 1'b1;
    hold(12);
    chk("R13 outputs after reset", {cnt_en, cnt_up, idx_load, idx_clear, idx_snap}, 0);
    clr_cnt();

    // table walk
    for (int r = 0; r < NV; r++) begin
      mode = VEC[r].m;
      drive(VEC[r].abi[2], VEC[r].abi[1], VEC[r].abi[0]);
      hold(12);
      chk(row_tag(r), {n_up[3:0], n_dn[3:0], n_ld[3:0], n_cl[3:0], n_sn[3:0]},
          {3'b0, VEC[r].ud[1], 3'b0, VEC[r].ud[0], 3'b0, VEC[r].stb[2],
           3'b0, VEC[r].stb[1], 3'b0, VEC[r].stb[0]});
      clr_cnt();
    end

    // R2: two-sample pulse rejected, three-sample accepted
    reset_with(8'h03, 1'b0, 1'b0, 1'b0);
    pulse_a(2);
    chk("R2 short pulse counts", n_up + n_dn, 0);
    clr_cnt();
    pulse_a(3);
    chk("R2 long pulse up", n_up, 1);
    chk("R2 long pulse down", n_dn, 1);

    // R1: divide by two
    reset_with(8'h83, 1'b0, 1'b0, 1'b0);
    pulse_a(3);
    chk("R1 div2 three-cycle pulse", n_up + n_dn, 0);
    clr_cnt();
    pulse_a(6);
    chk("R1 div2 six-cycle pulse", n_up * 10 + n_dn, 11);

    // R7 / R8: clock/direction, single-cycle pulses
    reset_with(8'h00, 1'b0, 1'b1, 1'b0);
    pulse_a(1);
    chk("R7 one-cycle up pulse", n_up * 10 + n_dn, 10);
    chk("R8 direction held up", cnt_up, 1);
    chk("R8 enable low between counts", cnt_en, 0);
    enc_b = 1'b0; hold(6); clr_cnt();
    pulse_a(1);
    chk("R7 one-cycle down pulse", n_up * 10 + n_dn, 1);
    chk("R8 direction held down", cnt_up, 0);

    // R10 / R12: active-low snapshot, once per entry, none after reset
    reset_with(8'h33, 1'b0, 1'b0, 1'b1);
    chk("R12 no strobe after reset", n_ld + n_cl + n_sn, 0);
    enc_idx = 1'b0; hold(20);
    chk("R10 active-low snapshot", n_sn * 100 + n_ld * 10 + n_cl, 100);
    clr_cnt();
    enc_idx = 1'b1; hold(12);
    chk("R12 no strobe on exit", n_ld + n_cl + n_sn, 0);

    // R11: clock/direction index unqualified by phases
    reset_with(8'h60, 1'b1, 1'b0, 1'b0);
    enc_idx = 1'b1; hold(12);
    chk("R11 clear in clock/direction with A!=B", n_cl * 10 + n_ld + n_sn, 10);

    // R9: index disabled
    reset_with(8'h43, 1'b0, 1'b0, 1'b0);
    enc_idx = 1'b1; hold(10); enc_idx = 1'b0; hold(10); enc_idx = 1'b1; hold(10);
    chk("R9 disabled index strobes", n_ld + n_cl + n_sn, 0);

    finish_run();
  end
endmodule